// File: doc/BRIEF.md
# Shared Interrupt Distributor for a Multi-Core Cluster

The block takes a set of shared external interrupt lines and steers each one to the processor cores of a cluster. Every shared line has its own small set of settings: which cores may receive it, whether it is captured on a rising edge or followed as an active-high level, whether it goes to all chosen cores at once or to one of them at a time in turn, and a mask bit. Software changes these settings one command at a time through a single command port carrying a code, a line index and a data word. The mode word of a line can be read back, so one field can be changed without disturbing the other.

Each core sees one output wire per shared line. Nothing reaches any core until the global enable has been turned on, and every line starts out masked. Edge-captured requests stay pending until software acknowledges them. In rotating delivery, one core is chosen at a time, and the choice moves to the next permitted core each time a delivered request is acknowledged. Inverted polarity is not offered. The local interrupt controllers inside the cores lie outside this block.

Top module: `irq_distributor`

## Requirements
- R1: After reset every line is masked, the global enable is off, destination masks and mode words are zero (direct delivery, level trigger), the rotation pointer of each line points at core 0, and every `core_irq` bit is low.
- R2: Command code 1 (set destination) writes `cmd_data[NUM_CORE-1:0]` as the destination mask of line `cmd_index`; bit c enables core c.
- R3: Command code 2 (set mode) stores `cmd_data[1:0]` as the distribution mode and `cmd_data[4]` as the trigger type (1 = rising edge, 0 = level). Command code 3 (read mode) places the mode word of line `cmd_index` on `rd_data` with `rd_valid` high in the following cycle; all bits other than 1:0 and 4 read as zero.
- R4: In direct delivery (mode 0, and the unused modes 2 and 3) an active line raises its output towards every core whose destination bit is set. Line s towards core c appears on `core_irq[s*NUM_CORE+c]`.
- R5: In rotating delivery (mode 1) an active line raises exactly one output: the first set destination bit at or after the rotation pointer, searching upward with wrap-around. An acknowledge while the line is delivering moves the pointer to the core after the chosen one.
- R6: In edge mode a rising edge on the input is held as pending and delivered until an acknowledge (command code 5) for that line; a new rising edge in the same cycle as the acknowledge keeps the request pending.
- R7: In level mode the output follows the live input level; an acknowledge does not clear it.
- R8: Command code 4 (set mask) masks the line when `cmd_data[0]` is 1 and unmasks it when 0. A masked line drives no output, but an edge arriving while masked stays pending and is delivered once unmasked.
- R9: Command code 6 (global enable) sets the enable to `cmd_data[0]`; while it is off every `core_irq` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 4 | Command code |
| cmd_index | input | IDX_W | Shared line index |
| cmd_data | input | DATA_W | Command data word |
| src_irq | input | NUM_SRC | Shared interrupt inputs |
| rd_valid | output | 1 | Readback word valid |
| rd_data | output | DATA_W | Readback mode word |
| core_irq | output | NUM_SRC*NUM_CORE | Per-line, per-core interrupt outputs |

## Verification
The bench drives an edge on a line that is masked and then unmasks it. A design that dropped masked edges would never deliver that request. It lines up an acknowledge with a fresh rising edge in the same cycle, which catches a design that lets the clear win and loses the second request. The rotation test uses a destination mask with a hole in it: a pointer that fails to skip a clear bit leaves the line silent, and a pointer that fails to wrap sticks on the top core. The mode word is written with all ones and read back, so reserved bits that leak through, or fields sitting at the wrong positions, show up directly in the value read.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_SET_DEST  = 4'd1,
    OP_SET_MODE  = 4'd2,
    OP_READ_MODE = 4'd3,
    OP_SET_MASK  = 4'd4,
    OP_ACK       = 4'd5,
    OP_ENABLE    = 4'd6
  } irqd_op_e;

  localparam logic [1:0] DIST_DIRECT = 2'd0;
  localparam logic [1:0] DIST_ROTATE = 2'd1;

  localparam int MODE_DIST_LSB = 0;
  localparam int MODE_TRIG_BIT = 4;
endpackage

// File: rtl/irqd_rst_sync.sv
module irqd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irqd_cmd_decode.sv
module irqd_cmd_decode
  import irqd_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [3:0]                     cmd_code,
  input  logic [IDX_W-1:0]               cmd_index,
  input  logic [DATA_W-1:0]              cmd_data,
  input  logic [NUM_SRC-1:0][1:0]        dist_cfg,
  input  logic [NUM_SRC-1:0]             trig_cfg,
  output logic [NUM_SRC-1:0]             wr_dest,
  output logic [NUM_SRC-1:0]             wr_mode,
  output logic [NUM_SRC-1:0]             wr_mask,
  output logic [NUM_SRC-1:0]             ack,
  output logic [NUM_CORE-1:0]            dest_val,
  output logic [1:0]                     dist_val,
  output logic                           trig_val,
  output logic                           bit0_val,
  output logic                           glb_en,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data
);
  logic              unused_data;
  logic [NUM_SRC-1:0] sel_line;
  logic              is_read;
  logic              en_d;
  logic              en_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_d;
  logic [DATA_W-1:0] rd_data_q;

  assign unused_data = ^cmd_data;

  assign dest_val = cmd_data[NUM_CORE-1:0];
  assign dist_val = cmd_data[MODE_DIST_LSB +: 2];
  assign trig_val = cmd_data[MODE_TRIG_BIT];
  assign bit0_val = cmd_data[0];

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      sel_line[s] = cmd_valid && (cmd_index == IDX_W'(s));
    end
  end

  assign wr_dest = (cmd_code == OP_SET_DEST) ? sel_line : '0;
  assign wr_mode = (cmd_code == OP_SET_MODE) ? sel_line : '0;
  assign wr_mask = (cmd_code == OP_SET_MASK) ? sel_line : '0;
  assign ack     = (cmd_code == OP_ACK)      ? sel_line : '0;
  assign is_read = cmd_valid && (cmd_code == OP_READ_MODE);

  always_comb begin
    en_d = en_q;
    if (cmd_valid && (cmd_code == OP_ENABLE)) en_d = cmd_data[0];
  end

  always_comb begin
    rd_data_d = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (sel_line[s]) begin
        rd_data_d[MODE_DIST_LSB +: 2] = dist_cfg[s];
        rd_data_d[MODE_TRIG_BIT]      = trig_cfg[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      en_q       <= en_d;
      rd_valid_q <= is_read;
      if (is_read) rd_data_q <= rd_data_d;
    end
  end

  assign glb_en   = en_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R3
  rd_valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> rd_valid);

  // R3
  rd_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[3:2] == 2'b00 && rd_data[DATA_W-1:5] == '0));
endmodule

// File: rtl/irqd_channel.sv
module irqd_channel
  import irqd_pkg::*;
#(
  parameter int NUM_CORE = 4,
  parameter int CW       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_in,
  input  logic                glb_en,
  input  logic                wr_dest,
  input  logic [NUM_CORE-1:0] dest_val,
  input  logic                wr_mode,
  input  logic [1:0]          dist_val,
  input  logic                trig_val,
  input  logic                wr_mask,
  input  logic                mask_val,
  input  logic                ack,
  output logic [1:0]          dist_cfg,
  output logic                trig_cfg,
  output logic [NUM_CORE-1:0] core_out
);
  logic [NUM_CORE-1:0] dest_q, dest_d;
  logic [1:0]          dist_q, dist_d;
  logic                trig_q, trig_d;
  logic                mask_q, mask_d;
  logic                pend_q, pend_d;
  logic                prev_q;
  logic [CW-1:0]       ptr_q, ptr_d;
  logic                rise;
  logic                active;
  logic                deliver;
  logic                rotate;
  logic [CW-1:0]       pick;
  logic [NUM_CORE-1:0] pick_hot;

  function automatic logic [CW-1:0] first_at_or_after(
    input logic [NUM_CORE-1:0] set, input logic [CW-1:0] start);
    logic [CW-1:0] res;
    logic          found;
    res   = start;
    found = 1'b0;
    for (int k = 0; k < NUM_CORE; k++) begin
      logic [CW-1:0] idx;
      idx = CW'((int'(start) + k) % NUM_CORE);
      if (!found && set[idx]) begin
        res   = idx;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  assign rise    = src_in && !prev_q;
  assign active  = trig_q ? pend_q : src_in;
  assign deliver = active && !mask_q && glb_en;
  assign rotate  = (dist_q == DIST_ROTATE);
  assign pick    = first_at_or_after(dest_q, ptr_q);

  always_comb begin
    pick_hot = '0;
    if (dest_q != '0) pick_hot[pick] = 1'b1;
  end

  assign core_out = !deliver ? '0 : (rotate ? pick_hot : dest_q);

  always_comb begin
    dest_d = dest_q;
    dist_d = dist_q;
    trig_d = trig_q;
    mask_d = mask_q;
    ptr_d  = ptr_q;
    if (wr_dest) dest_d = dest_val;
    if (wr_mode) begin
      dist_d = dist_val;
      trig_d = trig_val;
    end
    if (wr_mask) mask_d = mask_val;
    // an edge in the acknowledge cycle keeps the request alive
    if (!trig_q)   pend_d = 1'b0;
    else if (rise) pend_d = 1'b1;
    else if (ack)  pend_d = 1'b0;
    else           pend_d = pend_q;
    if (ack && deliver && rotate && dest_q != '0) begin
      ptr_d = (pick == CW'(NUM_CORE - 1)) ? '0 : pick + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      dist_q <= DIST_DIRECT;
      trig_q <= 1'b0;
      mask_q <= 1'b1;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      dest_q <= dest_d;
      dist_q <= dist_d;
      trig_q <= trig_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      prev_q <= src_in;
      ptr_q  <= ptr_d;
    end
  end

  assign dist_cfg = dist_q;
  assign trig_cfg = trig_q;

  // R8
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> (core_out == '0));

  // R5
  rotate_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |-> $onehot0(core_out));

  // R4
  within_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_out & ~dest_q) == '0);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && trig_q && !rise) |=> !pend_q);

  // R6
  edge_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && rise && !wr_mode) |=> pend_q);

  // R7
  level_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_q && !src_in) |-> (core_out == '0));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NUM_SRC  = 4,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [3:0]                   cmd_code,
  input  logic [IDX_W-1:0]             cmd_index,
  input  logic [DATA_W-1:0]            cmd_data,
  input  logic [NUM_SRC-1:0]           src_irq,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_SRC*NUM_CORE-1:0]  core_irq
);
  localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

  logic                      rst_s_n;
  logic [NUM_SRC-1:0][1:0]   dist_cfg;
  logic [NUM_SRC-1:0]        trig_cfg;
  logic [NUM_SRC-1:0]        wr_dest, wr_mode, wr_mask, ack;
  logic [NUM_CORE-1:0]       dest_val;
  logic [1:0]                dist_val;
  logic                      trig_val;
  logic                      bit0_val;
  logic                      glb_en;

  irqd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  irqd_cmd_decode #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CORE (NUM_CORE),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_index (cmd_index),
    .cmd_data  (cmd_data),
    .dist_cfg  (dist_cfg),
    .trig_cfg  (trig_cfg),
    .wr_dest   (wr_dest),
    .wr_mode   (wr_mode),
    .wr_mask   (wr_mask),
    .ack       (ack),
    .dest_val  (dest_val),
    .dist_val  (dist_val),
    .trig_val  (trig_val),
    .bit0_val  (bit0_val),
    .glb_en    (glb_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_line
    irqd_channel #(
      .NUM_CORE (NUM_CORE),
      .CW       (CW)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .src_in   (src_irq[s]),
      .glb_en   (glb_en),
      .wr_dest  (wr_dest[s]),
      .dest_val (dest_val),
      .wr_mode  (wr_mode[s]),
      .dist_val (dist_val),
      .trig_val (trig_val),
      .wr_mask  (wr_mask[s]),
      .mask_val (bit0_val),
      .ack      (ack[s]),
      .dist_cfg (dist_cfg[s]),
      .trig_cfg (trig_cfg[s]),
      .core_out (core_irq[s*NUM_CORE +: NUM_CORE])
    );
  end

  // R9
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !glb_en |-> (core_irq == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |-> (core_irq == '0 && !rd_valid));
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NC = 4;
  localparam int DW = 32;

  localparam logic [3:0] C_DEST = 4'd1;
  localparam logic [3:0] C_MODE = 4'd2;
  localparam logic [3:0] C_READ = 4'd3;
  localparam logic [3:0] C_MASK = 4'd4;
  localparam logic [3:0] C_ACK  = 4'd5;
  localparam logic [3:0] C_EN   = 4'd6;

  logic            clk;
  logic            rst_n;
  logic            cmd_valid;
  logic [3:0]      cmd_code;
  logic [1:0]      cmd_index;
  logic [DW-1:0]   cmd_data;
  logic [NS-1:0]   src_irq;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic [NS*NC-1:0] core_irq;

  int n_tests;
  int n_fail;

  irq_distributor #(.NUM_SRC(NS), .NUM_CORE(NC), .DATA_W(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_index (cmd_index),
    .cmd_data  (cmd_data),
    .src_irq   (src_irq),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .core_irq  (core_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] code, input int idx, input logic [DW-1:0] data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_index = 2'(idx);
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 4'd0;
    cmd_data  = '0;
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    src_irq[s] = 1'b1;
    @(negedge clk);
    src_irq[s] = 1'b0;
  endtask

  function automatic logic [NC-1:0] lane(input int s);
    return core_irq[s*NC +: NC];
  endfunction

  task automatic t_reset();
    check(64'(core_irq), 64'h0, "R1 outputs low after reset");
    cmd(C_READ, 2, '0);
    check(64'({rd_valid, rd_data}), 64'h1_0000_0000, "R1 mode word zero after reset");
    // unmask and enable without a destination: still nothing delivered
    src_irq[2] = 1'b1;
    cmd(C_EN, 0, 32'h1);
    cmd(C_MASK, 2, 32'h0);
    check(64'(lane(2)), 64'h0, "R1 destination empty after reset");
    cmd(C_MASK, 2, 32'h1);
    cmd(C_EN, 0, 32'h0);
    src_irq[2] = 1'b0;
  endtask

  task automatic t_mode_word();
    cmd(C_MODE, 1, 32'hFFFF_FFFF);
    cmd(C_READ, 1, '0);
    check(64'(rd_data), 64'h13, "R3 mode word fields and reserved bits");
    check(64'(rd_valid), 64'h1, "R3 readback valid");
    cmd(C_MODE, 1, 32'h0000_0011);
    cmd(C_READ, 1, '0);
    check(64'(rd_data), 64'h11, "R3 readback after rewrite");
  endtask

  task automatic t_direct_enable();
    cmd(C_DEST, 0, 32'h5);
    cmd(C_MODE, 0, 32'h0);
    src_irq[0] = 1'b1;
    @(negedge clk);
    check(64'(lane(0)), 64'h0, "R8 masked after reset");
    cmd(C_MASK, 0, 32'h0);
    check(64'(core_irq), 64'h0, "R9 nothing before global enable");
    cmd(C_EN, 0, 32'h1);
    check(64'(core_irq), 64'h5, "R4 R2 direct delivery to all destinations");
    cmd(C_MODE, 0, 32'h2);
    check(64'(core_irq), 64'h5, "R4 unused mode acts as direct");
    cmd(C_MODE, 0, 32'h0);
    cmd(C_MASK, 0, 32'h1);
    check(64'(core_irq), 64'h0, "R8 set mask silences line");
    cmd(C_MASK, 0, 32'h0);
    check(64'(core_irq), 64'h5, "R8 unmask restores line");
    cmd(C_ACK, 0, '0);
    check(64'(core_irq), 64'h5, "R7 acknowledge leaves level line active");
    @(negedge clk);
    src_irq[0] = 1'b0;
    #1;
    check(64'(core_irq), 64'h0, "R7 level line follows input low");
    src_irq[0] = 1'b1;
    cmd(C_EN, 0, 32'h0);
    check(64'(core_irq), 64'h0, "R9 disable forces outputs low");
    src_irq[0] = 1'b0;
    cmd(C_EN, 0, 32'h1);
  endtask

  task automatic t_edge();
    cmd(C_DEST, 1, 32'h2);
    cmd(C_MODE, 1, 32'h10);
    cmd(C_MASK, 1, 32'h0);
    check(64'(lane(1)), 64'h0, "R6 no request before edge");
    pulse(1);
    check(64'(lane(1)), 64'h2, "R6 edge captured");
    repeat (3) @(negedge clk);
    check(64'(lane(1)), 64'h2, "R6 request held with input low");
    cmd(C_ACK, 1, '0);
    check(64'(lane(1)), 64'h0, "R6 acknowledge clears request");
    cmd(C_MASK, 1, 32'h1);
    pulse(1);
    check(64'(lane(1)), 64'h0, "R8 masked edge not delivered");
    cmd(C_MASK, 1, 32'h0);
    check(64'(lane(1)), 64'h2, "R8 masked edge delivered after unmask");
    cmd(C_ACK, 1, '0);
  endtask

  task automatic t_ack_race();
    cmd(C_DEST, 3, 32'h1);
    cmd(C_MODE, 3, 32'h10);
    cmd(C_MASK, 3, 32'h0);
    pulse(3);
    check(64'(lane(3)), 64'h1, "R6 first edge pending");
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = C_ACK;
    cmd_index = 2'd3;
    src_irq[3] = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 4'd0;
    src_irq[3] = 1'b0;
    check(64'(lane(3)), 64'h1, "R6 edge during acknowledge kept");
    cmd(C_ACK, 3, '0);
    check(64'(lane(3)), 64'h0, "R6 later acknowledge clears");
  endtask

  task automatic t_rotate();
    cmd(C_DEST, 2, 32'hD);
    cmd(C_MODE, 2, 32'h11);
    cmd(C_MASK, 2, 32'h0);
    pulse(2);
    check(64'(lane(2)), 64'h1, "R5 first pick core 0");
    cmd(C_ACK, 2, '0);
    check(64'(lane(2)), 64'h0, "R5 cleared after acknowledge");
    pulse(2);
    check(64'(lane(2)), 64'h4, "R5 skips core without destination bit");
    cmd(C_ACK, 2, '0);
    pulse(2);
    check(64'(lane(2)), 64'h8, "R5 moves to top core");
    cmd(C_ACK, 2, '0);
    pulse(2);
    check(64'(lane(2)), 64'h1, "R5 wraps to core 0");
    cmd(C_ACK, 2, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_code  = 4'd0;
    cmd_index = 2'd0;
    cmd_data  = '0;
    src_irq   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode_word();
    t_direct_enable();
    t_edge();
    t_ack_race();
    t_rotate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule